// File: doc/BRIEF.md
# Host-DSP Mailbox with Interrupt Status

This block carries short messages between a host processor and a DSP through two one-word mailbox slots, one for each direction. Each side has four registers on a simple synchronous read/write port: a data register, a status register, an interrupt enable register and a doorbell register. When one side writes a data word into its outgoing slot, the slot is marked full. When the other side reads that word, the slot is marked empty again. Every event is recorded as a pending bit in the receiving side's status register.

The host has only one interrupt request line. Every host-bound source (message arrived, message taken, doorbell and the external front-end interrupt) is merged onto that line through its own enable bit. The host reads its status register to find which source fired, then writes ones to clear those bits. If all enables are left at zero, the same status bits support a purely polled protocol. The front-end interrupt is also passed straight to the DSP's interrupt input. It is latched for the host even while the DSP is held in reset. During that time the DSP port is inert and its side of the state is held clear.

Top module: `host_dsp_mailbox`

## Requirements
- R1: After reset, both slots are empty and every pending bit and enable bit is zero. Both interrupt outputs are low while the front-end input is low.
- R2: A data write (address 0) into an empty slot stores the word and marks the slot full. A read of address 0 on the other side returns that word combinationally and marks the slot empty at the next clock edge.
- R3: A data write into a slot that is already full is dropped, and the stored word is unchanged.
- R4: Pending bits are set one cycle after their event. Bit 0 is set when the peer's data write is accepted. Bit 1 is set when the peer reads this side's full outgoing slot. Bit 2 is the doorbell. Bit 3 exists on the host side only and is set in every cycle that the front-end input is high.
- R5: A write to the status register (address 1) clears each pending bit whose data bit is one and leaves the other bits alone. A set event in the same cycle wins over the clear.
- R6: The enable register (address 2) reads back the written value in bits 3:0. A side's interrupt output is high exactly when some pending bit and its enable bit are both one.
- R7: With every enable bit at zero, pending bits still set and can be read, but the interrupt line stays low (polled mode).
- R8: A write to address 3 with data bit 0 set raises pending bit 2 on the other side. Reading address 3 returns zero.
- R9: The DSP interrupt output is high in the same cycle that the front-end input is high. The host still latches the front-end bit while the DSP is in reset.
- R10: While the DSP reset input is low, DSP port reads return zero and DSP port writes and reads have no effect. The DSP pending and enable bits are held at zero.
- R11: Status bit 4 shows that the side's own outgoing slot is full, and status bit 5 shows that its incoming slot is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| dsp_rst_n | input | 1 | Low while the DSP is held in reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data, combinational from the address |
| dsp_wr_i | input | 1 | DSP register write strobe |
| dsp_rd_i | input | 1 | DSP register read strobe |
| dsp_addr_i | input | 2 | DSP register address |
| dsp_wdata_i | input | DW | DSP write data |
| dsp_rdata_o | output | DW | DSP read data, combinational from the address |
| fe_irq_i | input | 1 | Front-end interrupt request |
| host_irq_o | output | 1 | Single merged interrupt line to the host |
| dsp_irq_o | output | 1 | Interrupt line to the DSP |

## Verification
The assertions assume that every input changes synchronously to the clock and is stable around the rising edge. They also assume that the DSP reset input is a plain synchronous level that may rise or fall in any cycle. Strobes on a port may combine read and write in the same cycle, and the bus is given no protocol beyond that. The stimulus drives all inputs just after the falling edge from a fixed seed. It mixes random reads and writes on both ports, random front-end pulses and occasional bursts of DSP reset, so that every combination stays inside those assumptions.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    // Register selection on either port; the mapping is shared by both sides.
    typedef enum logic [1:0] {
        MBX_DATA = 2'd0,
        MBX_STAT = 2'd1,
        MBX_EN   = 2'd2,
        MBX_BELL = 2'd3
    } mbx_reg_e;

    // Pending source positions inside the status and enable registers.
    localparam int SRC_RX    = 0;
    localparam int SRC_TAKEN = 1;
    localparam int SRC_BELL  = 2;
    localparam int SRC_FE    = 3;
    localparam int NUM_SRC   = 4;

endpackage

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
module mbx_slot #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic [DW-1:0] data_o,
    output logic          full_o,
    output logic          acc_o,
    output logic          take_o
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        acc_o  = wr_i && !slot_q.full;
        take_o = rd_i && slot_q.full;
        if (take_o) begin
            slot_d.full = 1'b0;
        end
        if (acc_o) begin
            slot_d.data = wdata_i;
            slot_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign data_o = slot_q.data;
    assign full_o = slot_q.full;

endmodule

// File: rtl/mbx_side.sv
`timescale 1ns/1ps
module mbx_side
    import mbx_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [1:0]      addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NSRC-1:0] set_i,
    input  logic [DW-1:0]   in_data_i,
    input  logic            in_full_i,
    input  logic            out_full_i,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o,
    output logic            data_wr_o,
    output logic            data_rd_o,
    output logic            bell_o,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] en_o
);

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] en;
    } side_t;

    side_t side_d, side_q;

    logic            acc_wr;
    logic            acc_rd;
    logic [NSRC-1:0] clr_mask;
    logic            unused_wbits;

    assign unused_wbits = ^wdata_i[DW-1:NSRC];

    always_comb begin
        acc_wr    = wr_i && !hold_i;
        acc_rd    = rd_i && !hold_i;
        data_wr_o = acc_wr && (addr_i == MBX_DATA);
        data_rd_o = acc_rd && (addr_i == MBX_DATA);
        bell_o    = acc_wr && (addr_i == MBX_BELL) && wdata_i[0];
        clr_mask  = (acc_wr && (addr_i == MBX_STAT)) ? wdata_i[NSRC-1:0] : '0;

        side_d      = side_q;
        side_d.pend = (side_q.pend & ~clr_mask) | set_i;
        if (acc_wr && (addr_i == MBX_EN)) begin
            side_d.en = wdata_i[NSRC-1:0];
        end
        if (hold_i) begin
            side_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q <= '0;
        end else begin
            side_q <= side_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (!hold_i) begin
            unique case (addr_i)
                MBX_DATA: rdata_o = in_data_i;
                MBX_STAT: begin
                    rdata_o[NSRC-1:0] = side_q.pend;
                    rdata_o[NSRC]     = out_full_i;
                    rdata_o[NSRC+1]   = in_full_i;
                end
                MBX_EN:   rdata_o[NSRC-1:0] = side_q.en;
                default:  rdata_o = '0;
            endcase
        end
    end

    assign irq_o  = |(side_q.pend & side_q.en);
    assign pend_o = side_q.pend;
    assign en_o   = side_q.en;

endmodule

// File: rtl/host_dsp_mailbox.sv
`timescale 1ns/1ps
module host_dsp_mailbox
    import mbx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dsp_rst_n,
    input  logic          host_wr_i,
    input  logic          host_rd_i,
    input  logic [1:0]    host_addr_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic [DW-1:0] host_rdata_o,
    input  logic          dsp_wr_i,
    input  logic          dsp_rd_i,
    input  logic [1:0]    dsp_addr_i,
    input  logic [DW-1:0] dsp_wdata_i,
    output logic [DW-1:0] dsp_rdata_o,
    input  logic          fe_irq_i,
    output logic          host_irq_o,
    output logic          dsp_irq_o
);

    localparam int NSRC = NUM_SRC;

    // Slot toward the DSP (h2d) and toward the host (d2h).
    logic [DW-1:0]   h2d_data, d2h_data;
    logic            h2d_full, d2h_full;
    logic            h2d_acc, h2d_take, d2h_acc, d2h_take;

    logic            host_data_wr, host_data_rd, host_bell;
    logic            dsp_data_wr, dsp_data_rd, dsp_bell;
    logic [NSRC-1:0] host_set, dsp_set;
    logic [NSRC-1:0] host_pend, host_en, dsp_pend, dsp_en;
    logic            dsp_mbox_irq;

    always_comb begin
        host_set            = '0;
        host_set[SRC_RX]    = d2h_acc;
        host_set[SRC_TAKEN] = h2d_take;
        host_set[SRC_BELL]  = dsp_bell;
        host_set[SRC_FE]    = fe_irq_i;

        dsp_set             = '0;
        dsp_set[SRC_RX]     = h2d_acc;
        dsp_set[SRC_TAKEN]  = d2h_take;
        dsp_set[SRC_BELL]   = host_bell;
    end

    mbx_slot #(.DW(DW)) u_h2d (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (host_data_wr),
        .wdata_i (host_wdata_i),
        .rd_i    (dsp_data_rd),
        .data_o  (h2d_data),
        .full_o  (h2d_full),
        .acc_o   (h2d_acc),
        .take_o  (h2d_take)
    );

    mbx_slot #(.DW(DW)) u_d2h (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (dsp_data_wr),
        .wdata_i (dsp_wdata_i),
        .rd_i    (host_data_rd),
        .data_o  (d2h_data),
        .full_o  (d2h_full),
        .acc_o   (d2h_acc),
        .take_o  (d2h_take)
    );

    mbx_side #(.DW(DW), .NSRC(NSRC)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (1'b0),
        .wr_i       (host_wr_i),
        .rd_i       (host_rd_i),
        .addr_i     (host_addr_i),
        .wdata_i    (host_wdata_i),
        .set_i      (host_set),
        .in_data_i  (d2h_data),
        .in_full_i  (d2h_full),
        .out_full_i (h2d_full),
        .rdata_o    (host_rdata_o),
        .irq_o      (host_irq_o),
        .data_wr_o  (host_data_wr),
        .data_rd_o  (host_data_rd),
        .bell_o     (host_bell),
        .pend_o     (host_pend),
        .en_o       (host_en)
    );

    mbx_side #(.DW(DW), .NSRC(NSRC)) u_dsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (!dsp_rst_n),
        .wr_i       (dsp_wr_i),
        .rd_i       (dsp_rd_i),
        .addr_i     (dsp_addr_i),
        .wdata_i    (dsp_wdata_i),
        .set_i      (dsp_set),
        .in_data_i  (h2d_data),
        .in_full_i  (h2d_full),
        .out_full_i (d2h_full),
        .rdata_o    (dsp_rdata_o),
        .irq_o      (dsp_mbox_irq),
        .data_wr_o  (dsp_data_wr),
        .data_rd_o  (dsp_data_rd),
        .bell_o     (dsp_bell),
        .pend_o     (dsp_pend),
        .en_o       (dsp_en)
    );

    // The front-end request shares the DSP interrupt input.
    assign dsp_irq_o = dsp_mbox_irq | fe_irq_i;

endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
    parameter int DW   = 16,
    parameter int NSRC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dsp_rst_n,
    input logic            host_wr_i,
    input logic [1:0]      host_addr_i,
    input logic [DW-1:0]   host_wdata_i,
    input logic            dsp_rd_i,
    input logic [1:0]      dsp_addr_i,
    input logic            fe_irq_i,
    input logic            host_irq_o,
    input logic            dsp_irq_o,
    input logic [DW-1:0]   h2d_data,
    input logic            h2d_full,
    input logic [NSRC-1:0] host_pend,
    input logic [NSRC-1:0] host_en,
    input logic [NSRC-1:0] dsp_pend,
    input logic [NSRC-1:0] dsp_en
);

    logic dsp_takes_h2d;
    assign dsp_takes_h2d = dsp_rst_n && dsp_rd_i && (dsp_addr_i == 2'd0);

    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_addr_i == 2'd0 && !h2d_full) |=> h2d_full);

    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (h2d_full && !dsp_takes_h2d) |=> (h2d_full && $stable(h2d_data)));

    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |-> (host_en != '0) && (host_pend != '0));

    a_r7_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en == '0) |-> !host_irq_o);

    a_r8_bell_reaches_dsp: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_addr_i == 2'd3 && host_wdata_i[0] && dsp_rst_n) |=> dsp_pend[2]);

    a_r9_fe_to_dsp: assert property (@(posedge clk) disable iff (!rst_n)
        fe_irq_i |-> dsp_irq_o);

    a_r9_fe_latched: assert property (@(posedge clk) disable iff (!rst_n)
        fe_irq_i |=> host_pend[3]);

    a_r10_dsp_held: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_rst_n |=> (dsp_pend == '0) && (dsp_en == '0));

endmodule

bind host_dsp_mailbox mbx_checker #(.DW(DW), .NSRC(NSRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dsp_rst_n    (dsp_rst_n),
    .host_wr_i    (host_wr_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .dsp_rd_i     (dsp_rd_i),
    .dsp_addr_i   (dsp_addr_i),
    .fe_irq_i     (fe_irq_i),
    .host_irq_o   (host_irq_o),
    .dsp_irq_o    (dsp_irq_o),
    .h2d_data     (h2d_data),
    .h2d_full     (h2d_full),
    .host_pend    (host_pend),
    .host_en      (host_en),
    .dsp_pend     (dsp_pend),
    .dsp_en       (dsp_en)
);

// File: tb/test_host_dsp_mailbox.sv
`timescale 1ns/1ps
module test_host_dsp_mailbox;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dsp_rst_n = 1'b1;
    logic          host_wr_i = 1'b0, host_rd_i = 1'b0;
    logic [1:0]    host_addr_i = '0;
    logic [DW-1:0] host_wdata_i = '0;
    logic [DW-1:0] host_rdata_o;
    logic          dsp_wr_i = 1'b0, dsp_rd_i = 1'b0;
    logic [1:0]    dsp_addr_i = '0;
    logic [DW-1:0] dsp_wdata_i = '0;
    logic [DW-1:0] dsp_rdata_o;
    logic          fe_irq_i = 1'b0;
    logic          host_irq_o, dsp_irq_o;

    host_dsp_mailbox #(.DW(DW)) i_host_dsp_mailbox (
        .clk          (clk),
        .rst_n        (rst_n),
        .dsp_rst_n    (dsp_rst_n),
        .host_wr_i    (host_wr_i),
        .host_rd_i    (host_rd_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .dsp_wr_i     (dsp_wr_i),
        .dsp_rd_i     (dsp_rd_i),
        .dsp_addr_i   (dsp_addr_i),
        .dsp_wdata_i  (dsp_wdata_i),
        .dsp_rdata_o  (dsp_rdata_o),
        .fe_irq_i     (fe_irq_i),
        .host_irq_o   (host_irq_o),
        .dsp_irq_o    (dsp_irq_o)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Reference state, built from the requirements.
    logic [DW-1:0] m_h2d_data = '0, m_d2h_data = '0;
    logic          m_h2d_full = 1'b0, m_d2h_full = 1'b0;
    logic [3:0]    m_hp = '0, m_he = '0, m_dp = '0, m_de = '0;

    // Values observed in the last cycle, for directed checks.
    logic [DW-1:0] lh, ld;
    logic          lhi, ldi;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_host_rd(input logic [1:0] a);
        logic [DW-1:0] r = '0;
        case (a)
            2'd0: r = m_d2h_data;
            2'd1: begin r[3:0] = m_hp; r[4] = m_h2d_full; r[5] = m_d2h_full; end
            2'd2: r[3:0] = m_he;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_dsp_rd(input logic [1:0] a, input logic up);
        logic [DW-1:0] r = '0;
        if (up) begin
            case (a)
                2'd0: r = m_h2d_data;
                2'd1: begin r[3:0] = m_dp; r[4] = m_d2h_full; r[5] = m_h2d_full; end
                2'd2: r[3:0] = m_de;
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] a);
        case (a)
            2'd0: return "R2";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic cyc(input logic hw, input logic hr, input logic [1:0] ha, input logic [DW-1:0] hwd,
                       input logic dw, input logic dr, input logic [1:0] da, input logic [DW-1:0] dwd,
                       input logic fe, input logic up);
        logic          dwv, drv, h2d_acc, d2h_acc, h2d_take, d2h_take, hbell, dbell;
        logic [3:0]    hclr, dclr, hp_n, dp_n, he_n, de_n;
        logic [DW-1:0] h2d_dn, d2h_dn;
        logic          h2d_fn, d2h_fn;
        @(negedge clk);
        host_wr_i = hw; host_rd_i = hr; host_addr_i = ha; host_wdata_i = hwd;
        dsp_wr_i = dw; dsp_rd_i = dr; dsp_addr_i = da; dsp_wdata_i = dwd;
        fe_irq_i = fe; dsp_rst_n = up;
        #1;
        lh = host_rdata_o; ld = dsp_rdata_o; lhi = host_irq_o; ldi = dsp_irq_o;
        chk(tag_of(ha), host_rdata_o, exp_host_rd(ha));
        chk(up ? tag_of(da) : "R10", dsp_rdata_o, exp_dsp_rd(da, up));
        chk("R6", {15'd0, host_irq_o}, {15'd0, |(m_hp & m_he)});
        chk("R9", {15'd0, dsp_irq_o}, {15'd0, (|(m_dp & m_de)) | fe});

        dwv = dw && up; drv = dr && up;
        h2d_acc  = hw && ha == 2'd0 && !m_h2d_full;
        d2h_acc  = dwv && da == 2'd0 && !m_d2h_full;
        h2d_take = drv && da == 2'd0 && m_h2d_full;
        d2h_take = hr && ha == 2'd0 && m_d2h_full;
        hbell    = hw && ha == 2'd3 && hwd[0];
        dbell    = dwv && da == 2'd3 && dwd[0];
        hclr     = (hw && ha == 2'd1) ? hwd[3:0] : 4'h0;
        dclr     = (dwv && da == 2'd1) ? dwd[3:0] : 4'h0;
        hp_n     = (m_hp & ~hclr) | {fe, dbell, h2d_take, d2h_acc};
        dp_n     = up ? ((m_dp & ~dclr) | {1'b0, hbell, d2h_take, h2d_acc}) : 4'h0;
        he_n     = (hw && ha == 2'd2) ? hwd[3:0] : m_he;
        de_n     = up ? ((dwv && da == 2'd2) ? dwd[3:0] : m_de) : 4'h0;
        h2d_dn = m_h2d_data; h2d_fn = m_h2d_full;
        if (h2d_take) h2d_fn = 1'b0;
        if (h2d_acc) begin h2d_dn = hwd; h2d_fn = 1'b1; end
        d2h_dn = m_d2h_data; d2h_fn = m_d2h_full;
        if (d2h_take) d2h_fn = 1'b0;
        if (d2h_acc) begin d2h_dn = dwd; d2h_fn = 1'b1; end

        @(posedge clk);
        m_hp = hp_n; m_dp = dp_n; m_he = he_n; m_de = de_n;
        m_h2d_data = h2d_dn; m_h2d_full = h2d_fn;
        m_d2h_data = d2h_dn; m_d2h_full = d2h_fn;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset
        cyc(0, 1, 2'd1, '0, 0, 1, 2'd1, '0, 0, 1);
        chk("R1", lh, 16'h0000);
        chk("R1", ld, 16'h0000);
        chk("R1", {15'd0, lhi}, 16'h0000);
        chk("R1", {15'd0, ldi}, 16'h0000);

        // R2 / R3 / R4 / R11: message to the DSP, second write dropped
        cyc(1, 0, 2'd0, 16'hA5A5, 0, 0, 2'd0, '0, 0, 1);
        cyc(1, 0, 2'd0, 16'h1234, 0, 1, 2'd1, '0, 0, 1);
        chk("R4", ld, 16'h0021);
        cyc(0, 1, 2'd1, '0, 0, 1, 2'd0, '0, 0, 1);
        chk("R3", ld, 16'hA5A5);
        chk("R11", lh, 16'h0010);
        cyc(0, 1, 2'd1, '0, 0, 0, 2'd0, '0, 0, 1);
        chk("R4", lh, 16'h0002);
        chk("R7", {15'd0, lhi}, 16'h0000);

        // R6 / R5: enable then write-one-to-clear
        cyc(1, 0, 2'd2, 16'h0002, 0, 0, 2'd0, '0, 0, 1);
        cyc(0, 1, 2'd1, '0, 0, 0, 2'd0, '0, 0, 1);
        chk("R6", {15'd0, lhi}, 16'h0001);
        cyc(1, 0, 2'd1, 16'h0002, 0, 0, 2'd0, '0, 0, 1);
        cyc(0, 1, 2'd1, '0, 0, 0, 2'd0, '0, 0, 1);
        chk("R5", lh, 16'h0000);
        chk("R5", {15'd0, lhi}, 16'h0000);

        // R8: DSP doorbell
        cyc(0, 0, 2'd0, '0, 1, 0, 2'd3, 16'h0001, 0, 1);
        cyc(0, 1, 2'd1, '0, 0, 1, 2'd3, '0, 0, 1);
        chk("R8", lh, 16'h0004);
        chk("R8", ld, 16'h0000);
        cyc(1, 0, 2'd1, 16'h000F, 0, 0, 2'd0, '0, 0, 1);

        // R9 / R10: front-end request while the DSP is in reset
        cyc(1, 0, 2'd2, 16'h0008, 1, 0, 2'd2, 16'h000F, 1, 0);
        chk("R9", {15'd0, ldi}, 16'h0001);
        cyc(0, 1, 2'd1, '0, 0, 1, 2'd2, '0, 0, 0);
        chk("R9", lh, 16'h0008);
        chk("R9", {15'd0, lhi}, 16'h0001);
        chk("R10", ld, 16'h0000);
        cyc(0, 0, 2'd0, '0, 0, 1, 2'd2, '0, 0, 1);
        chk("R10", ld, 16'h0000);

        // Random traffic on both ports checked against the reference state.
        begin
            logic up = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(0, 99) < 2) up = ~up;
                cyc($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
                    2'($urandom_range(0, 3)), 16'($urandom()),
                    $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
                    2'($urandom_range(0, 3)), 16'($urandom()),
                    $urandom_range(0, 19) == 0, up);
            end
        end
        summary();
    end

endmodule